// File: doc/BRIEF.md
# Inherent-Mode Register Transfer Unit

This unit holds the programmer-visible register set of a small 8-bit CPU core and executes the inherent-mode instructions that copy, swap or test those registers. The set is two 8-bit accumulators `A` and `B`, which together form the 16-bit `D = A:B`, two 16-bit index registers `X` and `Y`, a 16-bit stack pointer and an 8-bit flag register. The flag register's bits, from bit 7 down to bit 0, are S, X, H, I, N, Z, V and C.

The sequencer offers a decoded opcode byte, plus a flag that says a 0x18 prefix came before it, on a valid/ready handshake. When the unit accepts an instruction it updates the registers in that same clock edge. It then holds `in_ready` low for the instruction's cycle count and pulses `done` in the following cycle. A prefix moves the three index-register instructions from X to Y and costs one extra cycle. The rest of the core writes register values, such as memory results, through a separate load port. All registers are visible on output ports.

Top module: `xfer_unit`

## Requirements
- R1: Reset clears A, B, X, Y and SP, sets the flag register to 0xD0 (S, X and I set), leaves the unit ready, and holds `done` and `err` low.
- R2: Opcode 0x16 copies A into B, and opcode 0x17 copies B into A. Both set N from bit 7 of the result and Z when the result is zero, clear V, and leave the other flags unchanged.
- R3: Opcodes 0x4D and 0x5D test A and B respectively. They set N and Z from the accumulator, clear V and C, and leave the accumulator and the other flags unchanged.
- R4: Opcode 0x06 copies A into the flag register, except that bit 6 (X) becomes A[6] AND its old value, so it can fall but never rise. Opcode 0x07 copies the flag register into A and leaves all flags unchanged.
- R5: Opcode 0x30 loads X (or Y when prefixed) with SP+1. Opcode 0x35 loads SP with X−1 (or Y−1 when prefixed). Arithmetic wraps modulo 2^16, and no flag changes.
- R6: Opcode 0x8F swaps D with X (or with Y when prefixed), and no flag changes.
- R7: After an accepted legal instruction, `in_ready` stays low for N cycles and `done` is high for exactly the next cycle. N is 2 for 0x16, 0x06, 0x17, 0x07, 0x4D and 0x5D, 3 for unprefixed 0x30, 0x35 and 0x8F, and 4 for prefixed 0x30, 0x35 and 0x8F.
- R8: An accepted opcode outside the legal set, including any prefixed opcode other than 0x30, 0x35 or 0x8F, raises `err` for exactly the next cycle. It leaves every register unchanged, does not drop `in_ready`, and does not raise `done`.
- R9: The load port writes `ld_data` into the register chosen by `ld_sel` (0 A, 1 B, 2 X, 3 Y, 4 SP, 5 flags; the 8-bit targets take the low byte, and selects 6 and 7 write nothing). The write happens only in a cycle where the unit is ready and no instruction is offered. In any other cycle it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, can accept an instruction |
| in_opcode | input | 8 | Opcode byte |
| in_pfx | input | 1 | Opcode was preceded by the 0x18 prefix |
| ld_en | input | 1 | Register load request |
| ld_sel | input | 3 | Load target select |
| ld_data | input | 16 | Load value |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-opcode pulse |
| reg_a | output | 8 | Accumulator A |
| reg_b | output | 8 | Accumulator B |
| reg_x | output | 16 | Index register X |
| reg_y | output | 16 | Index register Y |
| reg_sp | output | 16 | Stack pointer |
| reg_ccr | output | 8 | Flag register S X H I N Z V C |

## Verification
All state is on the ports, so a wrong register update shows on the register outputs one cycle after the accepting edge. A fault in the busy counter shows as a `done` pulse that comes too early or too late, measured from the accepting edge. A fault in legality decoding shows as a missing `err` pulse or as a register that changes when it should not. A fault in the X-bit rule can stay hidden until a 0x06 is executed with flag bit 6 clear and A[6] set, so the random mix loads the flags directly to reach that case often.

// File: rtl/xfer_unit.sv
module xfer_unit #(
  parameter int CW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_opcode,
  input  logic        in_pfx,
  input  logic        ld_en,
  input  logic [2:0]  ld_sel,
  input  logic [15:0] ld_data,
  output logic        done,
  output logic        err,
  output logic [7:0]  reg_a,
  output logic [7:0]  reg_b,
  output logic [15:0] reg_x,
  output logic [15:0] reg_y,
  output logic [15:0] reg_sp,
  output logic [7:0]  reg_ccr
);

  localparam logic [7:0] CCR_RST = 8'hD0;

  logic          busy;
  logic [CW-1:0] cnt;
  logic          legal;
  logic [CW-1:0] ncyc;
  logic          take;
  logic [15:0]   idx;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;
  assign idx      = in_pfx ? reg_y : reg_x;

  always_comb begin
    legal = 1'b1;
    ncyc  = CW'(2);
    unique case (in_opcode)
      8'h30, 8'h35, 8'h8F: ncyc = in_pfx ? CW'(4) : CW'(3);
      8'h16, 8'h06, 8'h17, 8'h07, 8'h4D, 8'h5D: legal = !in_pfx;
      default: legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= take && !legal;
      if (take && legal) begin
        busy <= 1'b1;
        cnt  <= ncyc;
      end else if (busy) begin
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a   <= '0;
      reg_b   <= '0;
      reg_x   <= '0;
      reg_y   <= '0;
      reg_sp  <= '0;
      reg_ccr <= CCR_RST;
    end else if (take && legal) begin
      unique case (in_opcode)
        8'h16: begin
          reg_b   <= reg_a;
          reg_ccr <= {reg_ccr[7:4], reg_a[7], reg_a == 8'h00, 1'b0, reg_ccr[0]};
        end
        8'h17: begin
          reg_a   <= reg_b;
          reg_ccr <= {reg_ccr[7:4], reg_b[7], reg_b == 8'h00, 1'b0, reg_ccr[0]};
        end
        8'h4D: reg_ccr <= {reg_ccr[7:4], reg_a[7], reg_a == 8'h00, 2'b00};
        8'h5D: reg_ccr <= {reg_ccr[7:4], reg_b[7], reg_b == 8'h00, 2'b00};
        8'h06: reg_ccr <= {reg_a[7], reg_a[6] & reg_ccr[6], reg_a[5:0]};
        8'h07: reg_a   <= reg_ccr;
        8'h30: begin
          if (in_pfx) reg_y <= reg_sp + 16'd1;
          else        reg_x <= reg_sp + 16'd1;
        end
        8'h35: reg_sp <= idx - 16'd1;
        8'h8F: begin
          {reg_a, reg_b} <= idx;
          if (in_pfx) reg_y <= {reg_a, reg_b};
          else        reg_x <= {reg_a, reg_b};
        end
        default: ;
      endcase
    end else if (ld_en && !busy && !in_valid) begin
      unique case (ld_sel)
        3'd0: reg_a   <= ld_data[7:0];
        3'd1: reg_b   <= ld_data[7:0];
        3'd2: reg_x   <= ld_data;
        3'd3: reg_y   <= ld_data;
        3'd4: reg_sp  <= ld_data;
        3'd5: reg_ccr <= ld_data[7:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/xfer_unit_chk.sv
module xfer_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_opcode,
  input logic        in_pfx,
  input logic        ld_en,
  input logic [2:0]  ld_sel,
  input logic        done,
  input logic        err,
  input logic [7:0]  reg_a,
  input logic [7:0]  reg_b,
  input logic [15:0] reg_x,
  input logic [15:0] reg_y,
  input logic [15:0] reg_sp,
  input logic [7:0]  reg_ccr
);

  logic ok_op;
  assign ok_op = (in_opcode == 8'h30) || (in_opcode == 8'h35) || (in_opcode == 8'h8F) ||
                 (!in_pfx && ((in_opcode == 8'h16) || (in_opcode == 8'h17) ||
                              (in_opcode == 8'h06) || (in_opcode == 8'h07) ||
                              (in_opcode == 8'h4D) || (in_opcode == 8'h5D)));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ok_op |=> !in_ready);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  // R8
  err_on_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !ok_op |=> err && in_ready && !done);

  // R8
  err_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(reg_a) && $stable(reg_b) && $stable(reg_x) &&
            $stable(reg_y) && $stable(reg_sp) && $stable(reg_ccr));

  // R4
  xbit_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_ccr[6]) |-> $past(ld_en && ld_sel == 3'd5 && in_ready && !in_valid));

  // R6
  swap_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode == 8'h8F |=> $stable(reg_ccr));

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done);

endmodule

bind xfer_unit xfer_unit_chk i_xfer_unit_chk (.*);

// File: tb/test_xfer_unit.sv
module test_xfer_unit;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, in_valid = 0, in_pfx = 0, ld_en = 0;
  logic [7:0] in_opcode = 0;
  logic [2:0] ld_sel = 0;
  logic [15:0] ld_data = 0;
  logic in_ready, done, err;
  logic [7:0] reg_a, reg_b, reg_ccr;
  logic [15:0] reg_x, reg_y, reg_sp;

  int n_chk = 0, n_pass = 0;
  logic [7:0] ea, eb, ec;
  logic [15:0] ex, ey, es;

  always #(TCLK/2) clk = ~clk;

  xfer_unit i_xfer_unit (.*);

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act === exp) n_pass++;
    else $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
  endtask

  function automatic bit legal_op(input logic [7:0] op, input bit p);
    if (op == 8'h30 || op == 8'h35 || op == 8'h8F) return 1;
    if (p) return 0;
    return op == 8'h16 || op == 8'h17 || op == 8'h06 || op == 8'h07 || op == 8'h4D || op == 8'h5D;
  endfunction

  function automatic int cyc_of(input logic [7:0] op, input bit p);
    if (op == 8'h30 || op == 8'h35 || op == 8'h8F) return p ? 4 : 3;
    return 2;
  endfunction

  function automatic logic [3:0] nzv(input logic [7:0] r, input logic c);
    return {r[7], r == 8'h00, 1'b0, c};
  endfunction

  task automatic model(input logic [7:0] op, input bit p);
    logic [15:0] t;
    case (op)
      8'h16: begin eb = ea; ec[3:0] = nzv(ea, ec[0]); end
      8'h17: begin ea = eb; ec[3:0] = nzv(eb, ec[0]); end
      8'h4D: ec[3:0] = nzv(ea, 1'b0);
      8'h5D: ec[3:0] = nzv(eb, 1'b0);
      8'h06: begin ec = ea; ec[6] = ea[6] && ec_old6; end
      8'h07: ea = ec;
      8'h30: if (p) ey = es + 1; else ex = es + 1;
      8'h35: es = (p ? ey : ex) - 1;
      8'h8F: begin t = {ea, eb}; {ea, eb} = p ? ey : ex; if (p) ey = t; else ex = t; end
      default: ;
    endcase
  endtask
  logic ec_old6;

  task automatic check_regs(input string rq);
    check({rq, " A"}, reg_a, ea);
    check({rq, " B"}, reg_b, eb);
    check({rq, " X"}, reg_x, ex);
    check({rq, " Y"}, reg_y, ey);
    check({rq, " SP"}, reg_sp, es);
    check({rq, " CCR"}, reg_ccr, ec);
  endtask

  task automatic load(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); ld_en = 1; ld_sel = s; ld_data = d;
    @(negedge clk); ld_en = 0;
    case (s)
      0: ea = d[7:0]; 1: eb = d[7:0]; 2: ex = d; 3: ey = d; 4: es = d; 5: ec = d[7:0];
      default: ;
    endcase
  endtask

  task automatic exec(input logic [7:0] op, input bit p, input string rq, input bit poke);
    int n;
    bit lg;
    lg = legal_op(op, p);
    @(negedge clk); in_valid = 1; in_opcode = op; in_pfx = p;
    @(negedge clk); in_valid = 0;
    ec_old6 = ec[6];
    if (lg) model(op, p);
    n = 1;
    if (lg) begin
      check({rq, " R7 busy"}, in_ready, 1'b0);
      if (poke) begin ld_en = 1; ld_sel = 3'd0; ld_data = 16'h00A5; end
      while (!done && n < 10) begin @(negedge clk); ld_en = 0; n++; end
      check({rq, " R7 cycles"}, n - 1, cyc_of(op, p));
      check({rq, " R7 ready"}, in_ready, 1'b1);
      @(negedge clk);
      check({rq, " R7 done pulse"}, done, 1'b0);
      check_regs(poke ? "R9 busy load" : rq);
    end else begin
      check("R8 err", err, 1'b1);
      check("R8 ready", in_ready, 1'b1);
      check("R8 no done", done, 1'b0);
      check_regs("R8");
      @(negedge clk);
      check("R8 err pulse", err, 1'b0);
    end
  endtask

  initial begin
    #(TCLK * 150000);
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    ea = 0; eb = 0; ex = 0; ey = 0; es = 0; ec = 8'hD0;
    check_regs("R1");
    check("R1 ready", in_ready, 1'b1);
    check("R1 done", done, 1'b0);
    check("R1 err", err, 1'b0);

    load(0, 16'h0080); exec(8'h16, 0, "R2 TAB neg", 0);
    load(1, 16'h0000); exec(8'h17, 0, "R2 TBA zero", 0);
    load(0, 16'h00F3); exec(8'h4D, 0, "R3 TSTA", 0);
    load(5, 16'h0001); exec(8'h5D, 0, "R3 TSTB", 0);
    load(0, 16'h00FF); exec(8'h06, 0, "R4 TAP x low", 0);
    check("R4 X stays 0", reg_ccr[6], 1'b0);
    load(5, 16'h00FF); load(0, 16'h0000); exec(8'h06, 0, "R4 TAP x fall", 0);
    exec(8'h07, 0, "R4 TPA", 0);
    load(4, 16'hFFFF); exec(8'h30, 0, "R5 TSX wrap", 0);
    load(3, 16'h0000); exec(8'h35, 1, "R5 TYS wrap", 0);
    exec(8'h30, 1, "R5 TSY", 0);
    load(2, 16'h1234); exec(8'h8F, 0, "R6 XGDX", 0);
    load(3, 16'hBEEF); exec(8'h8F, 1, "R6 XGDY", 0);
    exec(8'h16, 1, "R8", 0);
    exec(8'h00, 0, "R8", 0);
    exec(8'h35, 0, "R9", 1);
    @(negedge clk); in_valid = 1; in_opcode = 8'h07; in_pfx = 0;
    ld_en = 1; ld_sel = 3'd1; ld_data = 16'h0055;
    @(negedge clk); in_valid = 0; ld_en = 0; ec_old6 = ec[6]; model(8'h07, 0);
    repeat (3) @(negedge clk);
    check_regs("R9 load with offer");
    load(6, 16'hFFFF); check_regs("R9 sel 6");

    for (int i = 0; i < 600; i++) begin
      int k;
      logic [7:0] ops[9] = '{8'h16, 8'h06, 8'h17, 8'h07, 8'h4D, 8'h5D, 8'h30, 8'h35, 8'h8F};
      if ($urandom_range(2) == 0) load(3'($urandom_range(5)), 16'($urandom));
      k = $urandom_range(10);
      if (k < 9) exec(ops[k], bit'($urandom_range(1)) && k >= 6, "R2-7 rnd", 0);
      else exec(8'($urandom), bit'($urandom_range(1)), "R8 rnd", 0);
    end

    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule